// File: doc/BRIEF.md
# Multi-Step Conversion Sequencer

The block walks a table of sixteen step descriptors and drives an external analog-to-digital converter through a start/done/data handshake. Each step has its own delays, averaging depth, input selection, differential flag and destination FIFO. For every enabled step the block waits a programmable open delay and then a sample delay. It then issues one or more conversion requests, averages the returned codes and pushes a 12-bit result into one of two result FIFOs.

Software reaches the block through a word-addressed register port with a combinational read path. Through it, software arms steps, starts and stops the sequencer, and reads the step in progress. It also drains the FIFOs and services a write-one-to-clear interrupt status register with a matching enable mask. A step runs once or repeats, depending on its mode. Single-shot steps disarm themselves after they finish, so a table of single-shot steps runs one pass and then returns to idle.

Top module: `adc_step_seq`

## Requirements
- R1: Registers are decoded by word address: 0 control, 1 status, 2 step arm, 3 interrupt status, 4 interrupt enable, 5/6/7 FIFO0 count/threshold/data, 8/9/10 FIFO1 count/threshold/data, 32+2j step j config, 33+2j step j delay. After reset, status reads 0x10, the FIFO counts and arm register read 0, and irq_o is low.
- R2: Step j is armed by bit j+1 of the arm register, and bit 0 arms nothing and reads as 0. Armed steps run in ascending index order within a pass.
- R3: The config word of a step uses bits 1:0 for mode, 4:2 for averaging, 18:15 for negative input, 22:19 for positive input, bit 25 for differential and bit 26 for FIFO select. The delay word uses bits 17:0 for open delay O and bits 31:24 for sample delay S. The first conversion request of a step comes O+S+2 cycles after the step begins, which is O+S+3 cycles after the control write that starts an idle sequencer.
- R4: Averaging code n runs 2^n conversions and stores their sum shifted right by n. Codes above 4 behave as 4.
- R5: Config bit 26 picks FIFO1 (1) or FIFO0 (0), and the other FIFO is untouched. The result reads in bits 11:0 of the data address, and each data read pops one word.
- R6: A step with mode 0 (single-shot) clears its own arm bit when it completes.
- R7: A step with a non-zero mode stays armed and is run again on every pass while the sequencer is enabled.
- R8: Interrupt status bit 1 (end of sequence) sets when a pass ends. With nothing armed the sequencer then goes idle, and status reads busy (bit 5) = 0 with step field (bits 4:0) = 0x10. While busy, the step field holds the step index.
- R9: A result pushed into a full FIFO is dropped and sets overflow: bit 3 for FIFO0, bit 6 for FIFO1.
- R10: Reading the data address of an empty FIFO returns 0 and sets underflow: bit 4 for FIFO0, bit 7 for FIFO1.
- R11: While the word count is at or above a non-zero threshold, the threshold bit sets: bit 2 for FIFO0, bit 5 for FIFO1.
- R12: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged. irq_o is high when any status bit is set whose enable bit is also set.
- R13: No step starts while control bit 0 (enable) is 0 or control bit 4 (power-down) is 1.
- R14: During a step, conv_pos_o, conv_neg_o and conv_diff_o carry that step's input selection and differential flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on FIFO data addresses) |
| reg_addr_i | input | 6 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_pos_o | output | 4 | Positive input select |
| conv_neg_o | output | 4 | Negative input select |
| conv_diff_o | output | 1 | Differential conversion |
| conv_done_i | input | 1 | Conversion complete, data valid |
| conv_data_i | input | 12 | Conversion code |

## Verification
The bench measures the exact cycle of the first conversion request against the open and sample delays. An off-by-one in either counter would shift that request by a cycle. It runs averaging codes 0, 1, 2, 4 and an out-of-range 6 against a converter that returns a rising ramp. A wrong shift or a missing clamp would change both the number of requests and the stored word. A single-shot step that failed to disarm, or a continuous step that disarmed, would show up in the arm register read after the sequencer stops. A FIFO that wrapped on overflow instead of dropping would return a later ramp value in place of the first. An empty read that popped stale data would miss the underflow flag and the zero.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_SAMP, S_REQ, S_WAIT, S_STORE} seq_state_e;

  localparam int AVG_MAX    = 4;
  localparam int CF_AVG_LO  = 2;
  localparam int CF_NEG_LO  = 15;
  localparam int CF_POS_LO  = 19;
  localparam int CF_DIFF    = 25;
  localparam int CF_FIFO    = 26;
  localparam int DL_SAMP_LO = 24;

  localparam int IRQ_W      = 9;
  localparam int IRQ_EOS    = 1;
  localparam int IRQ_F_BASE = 2;  // per FIFO: thr, ovf, udf

  localparam int A_CTRL     = 0;
  localparam int A_STATUS   = 1;
  localparam int A_ARM      = 2;
  localparam int A_IRQ_STS  = 3;
  localparam int A_IRQ_EN   = 4;
  localparam int A_F_BASE   = 5;  // per FIFO: count, thr, data
  localparam int A_CFG_BASE = 32;
endpackage

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, empty, do_push, do_pop;

  assign full    = cnt_q == CNT_W'(DEPTH);
  assign empty   = cnt_q == '0;
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign ovf_o   = push_i && full;
  assign udf_o   = pop_i && empty;
  assign data_o  = empty ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (do_push) mem_q[wr_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> $stable(count_o));
  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> count_o == '0);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine import adc_seq_pkg::*; #(
  parameter int STEPS  = 16,
  parameter int RES_W  = 12,
  parameter int OPEN_W = 18,
  parameter int SAMP_W = 8,
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [STEPS-1:0]       arm_i,
  input  logic [STEPS-1:0][31:0] cfg_i,
  input  logic [STEPS-1:0][31:0] dly_i,
  output logic                   busy_o,
  output logic [IDX_W-1:0]       step_o,
  output logic                   conv_start_o,
  output logic [3:0]             conv_pos_o,
  output logic [3:0]             conv_neg_o,
  output logic                   conv_diff_o,
  input  logic                   conv_done_i,
  input  logic [RES_W-1:0]       conv_data_i,
  output logic                   push_o,
  output logic                   push_sel_o,
  output logic [RES_W-1:0]       push_data_o,
  output logic                   clr_o,
  output logic                   eos_o
);
  localparam int ACC_W = RES_W + AVG_MAX;
  localparam int NUM_W = AVG_MAX + 1;

  seq_state_e        state_q;
  logic [IDX_W-1:0]  step_q, first_idx, above_idx;
  logic              first_vld, above_vld, single;
  logic [OPEN_W-1:0] cnt_q;
  logic [NUM_W-1:0]  num_q, last_num;
  logic [ACC_W-1:0]  acc_q;
  logic [2:0]        avg;
  logic [31:0]       cur_cfg;
  logic [STEPS-1:0]  arm_m;

  always_comb begin
    cur_cfg  = cfg_i[step_q];
    avg      = (cur_cfg[CF_AVG_LO +: 3] > 3'(AVG_MAX)) ? 3'(AVG_MAX) : cur_cfg[CF_AVG_LO +: 3];
    last_num = (NUM_W'(1) << avg) - NUM_W'(1);
    single   = cur_cfg[1:0] == 2'b00;
    arm_m    = arm_i;
    if (state_q == S_STORE && single) arm_m[step_q] = 1'b0;
    first_vld = 1'b0; first_idx = '0;
    above_vld = 1'b0; above_idx = '0;
    for (int i = STEPS - 1; i >= 0; i--) begin
      if (arm_m[i]) begin
        first_vld = 1'b1; first_idx = IDX_W'(i);
        if (IDX_W'(i) > step_q) begin above_vld = 1'b1; above_idx = IDX_W'(i); end
      end
    end
  end

  assign busy_o       = state_q != S_IDLE;
  assign step_o       = step_q;
  assign conv_start_o = state_q == S_REQ;
  assign conv_pos_o   = cur_cfg[CF_POS_LO +: 4];
  assign conv_neg_o   = cur_cfg[CF_NEG_LO +: 4];
  assign conv_diff_o  = cur_cfg[CF_DIFF];
  assign push_o       = state_q == S_STORE;
  assign push_sel_o   = cur_cfg[CF_FIFO];
  assign push_data_o  = RES_W'(acc_q >> avg);
  assign clr_o        = push_o && single;
  assign eos_o        = push_o && !(go_i && above_vld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; step_q <= '0; cnt_q <= '0; num_q <= '0; acc_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_i && first_vld) begin
          step_q <= first_idx; cnt_q <= dly_i[first_idx][OPEN_W-1:0]; state_q <= S_OPEN;
        end
        S_OPEN: if (cnt_q == '0) begin
          cnt_q <= OPEN_W'(dly_i[step_q][DL_SAMP_LO +: SAMP_W]); state_q <= S_SAMP;
        end else cnt_q <= cnt_q - 1'b1;
        S_SAMP: if (cnt_q == '0) begin
          acc_q <= '0; num_q <= '0; state_q <= S_REQ;
        end else cnt_q <= cnt_q - 1'b1;
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (conv_done_i) begin
          acc_q <= acc_q + ACC_W'(conv_data_i);
          if (num_q == last_num) state_q <= S_STORE;
          else begin num_q <= num_q + 1'b1; state_q <= S_REQ; end
        end
        S_STORE: if (go_i && above_vld) begin
          step_q <= above_idx; cnt_q <= dly_i[above_idx][OPEN_W-1:0]; state_q <= S_OPEN;
        end else if (go_i && first_vld) begin
          step_q <= first_idx; cnt_q <= dly_i[first_idx][OPEN_W-1:0]; state_q <= S_OPEN;
        end else state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R13
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !go_i) |=> !busy_o);
  // R8
  eos_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_o && !go_i) |=> !busy_o);
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq import adc_seq_pkg::*; #(
  parameter int STEPS      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int RES_W      = 12,
  parameter int ADDR_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              conv_start_o,
  output logic [3:0]        conv_pos_o,
  output logic [3:0]        conv_neg_o,
  output logic              conv_diff_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i
);
  localparam int IDX_W = $clog2(STEPS);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic                   en_q, pd_q;
  logic [STEPS-1:0]       arm_q;
  logic [STEPS-1:0][31:0] cfg_q, dly_q;
  logic [IRQ_W-1:0]       sts_q, en_msk_q, irq_set, w1c;
  logic [CNT_W-1:0]       thr_q [2];
  logic [CNT_W-1:0]       f_cnt [2];
  logic [RES_W-1:0]       f_dat [2];
  logic [1:0]             f_ovf, f_udf, f_thr;

  logic             eng_busy, eng_push, eng_sel, eng_clr, eng_eos;
  logic [IDX_W-1:0] eng_step;
  logic [RES_W-1:0] eng_data;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int x);
    return a == ADDR_W'(x);
  endfunction

  adc_seq_engine #(.STEPS(STEPS), .RES_W(RES_W)) u_eng (
    .clk_i, .rst_ni, .go_i(en_q && !pd_q), .arm_i(arm_q), .cfg_i(cfg_q), .dly_i(dly_q),
    .busy_o(eng_busy), .step_o(eng_step), .conv_start_o, .conv_pos_o, .conv_neg_o,
    .conv_diff_o, .conv_done_i, .conv_data_i, .push_o(eng_push), .push_sel_o(eng_sel),
    .push_data_o(eng_data), .clr_o(eng_clr), .eos_o(eng_eos));

  for (genvar f = 0; f < 2; f++) begin : g_fifo
    adc_res_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(eng_push && (eng_sel == 1'(f))), .data_i(eng_data),
      .pop_i(reg_re_i && hit(reg_addr_i, A_F_BASE + 3*f + 2)),
      .data_o(f_dat[f]), .count_o(f_cnt[f]), .ovf_o(f_ovf[f]), .udf_o(f_udf[f]));
    assign f_thr[f] = (thr_q[f] != '0) && (f_cnt[f] >= thr_q[f]);
  end

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_EOS] = eng_eos;
    for (int f = 0; f < 2; f++) begin
      irq_set[IRQ_F_BASE + 3*f]     = f_thr[f];
      irq_set[IRQ_F_BASE + 3*f + 1] = f_ovf[f];
      irq_set[IRQ_F_BASE + 3*f + 2] = f_udf[f];
    end
    w1c = (reg_we_i && hit(reg_addr_i, A_IRQ_STS)) ? reg_wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; pd_q <= 1'b0; arm_q <= '0; cfg_q <= '0; dly_q <= '0;
      sts_q <= '0; en_msk_q <= '0; thr_q[0] <= '0; thr_q[1] <= '0;
    end else begin
      sts_q <= (sts_q & ~w1c) | irq_set;
      if (reg_we_i) begin
        if (hit(reg_addr_i, A_CTRL))   begin en_q <= reg_wdata_i[0]; pd_q <= reg_wdata_i[4]; end
        if (hit(reg_addr_i, A_ARM))    arm_q <= reg_wdata_i[STEPS:1];
        if (hit(reg_addr_i, A_IRQ_EN)) en_msk_q <= reg_wdata_i[IRQ_W-1:0];
        for (int f = 0; f < 2; f++)
          if (hit(reg_addr_i, A_F_BASE + 3*f + 1)) thr_q[f] <= reg_wdata_i[CNT_W-1:0];
        for (int j = 0; j < STEPS; j++) begin
          if (hit(reg_addr_i, A_CFG_BASE + 2*j))     cfg_q[j] <= reg_wdata_i;
          if (hit(reg_addr_i, A_CFG_BASE + 2*j + 1)) dly_q[j] <= reg_wdata_i;
        end
      end
      if (eng_clr) arm_q[eng_step] <= 1'b0;  // engine disarm wins over software
    end
  end

  assign irq_o = |(sts_q & en_msk_q);

  always_comb begin
    reg_rdata_o = '0;
    if (hit(reg_addr_i, A_CTRL))    reg_rdata_o = {27'd0, pd_q, 3'd0, en_q};
    if (hit(reg_addr_i, A_STATUS))  reg_rdata_o = {26'd0, eng_busy, eng_busy ? 5'(eng_step) : 5'h10};
    if (hit(reg_addr_i, A_ARM))     reg_rdata_o = 32'({arm_q, 1'b0});
    if (hit(reg_addr_i, A_IRQ_STS)) reg_rdata_o = 32'(sts_q);
    if (hit(reg_addr_i, A_IRQ_EN))  reg_rdata_o = 32'(en_msk_q);
    for (int f = 0; f < 2; f++) begin
      if (hit(reg_addr_i, A_F_BASE + 3*f))     reg_rdata_o = 32'(f_cnt[f]);
      if (hit(reg_addr_i, A_F_BASE + 3*f + 1)) reg_rdata_o = 32'(thr_q[f]);
      if (hit(reg_addr_i, A_F_BASE + 3*f + 2)) reg_rdata_o = 32'(f_dat[f]);
    end
    for (int j = 0; j < STEPS; j++) begin
      if (hit(reg_addr_i, A_CFG_BASE + 2*j))     reg_rdata_o = cfg_q[j];
      if (hit(reg_addr_i, A_CFG_BASE + 2*j + 1)) reg_rdata_o = dly_q[j];
    end
  end

  // R12
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && hit(reg_addr_i, A_IRQ_STS) && reg_wdata_i[IRQ_EOS] && !eng_eos)
    |=> !sts_q[IRQ_EOS]);
  // R12
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[IRQ_EOS] && !(reg_we_i && hit(reg_addr_i, A_IRQ_STS))) |=> sts_q[IRQ_EOS]);
  // R6
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_clr && !reg_we_i) |=> !arm_q[$past(eng_step)]);
endmodule

// File: tb/adc_step_seq_bench.sv
`timescale 1ns/1ps
module adc_step_seq_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 0, reg_re = 0, conv_done = 0, irq, conv_start, conv_diff;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  conv_pos, conv_neg;
  logic [11:0] conv_data = '0;

  always #2 clk = ~clk;

  adc_step_seq u_adc_step_seq (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .conv_start_o(conv_start), .conv_pos_o(conv_pos), .conv_neg_o(conv_neg),
    .conv_diff_o(conv_diff), .conv_done_i(conv_done), .conv_data_i(conv_data));

  int checks = 0, failures = 0;
  int cyc = 0, wr_cyc = 0, st_cyc = 0, conv_k = 0, pend = 0;
  logic armed = 0, cap_diff;
  logic [3:0] cap_pos, cap_neg;

  typedef struct packed {
    logic [2:0] avg; logic fifo; logic [3:0] pos; logic [3:0] neg;
    logic diff; logic [17:0] opn; logic [7:0] smp;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{3'd0, 1'b0, 4'd1,  4'd8, 1'b0, 18'd0,  8'd0},
    '{3'd1, 1'b1, 4'd3,  4'd8, 1'b0, 18'd5,  8'd2},
    '{3'd2, 1'b0, 4'd9,  4'd4, 1'b1, 18'd17, 8'd0},
    '{3'd4, 1'b1, 4'd15, 4'd8, 1'b0, 18'd0,  8'd9},
    '{3'd6, 1'b0, 4'd6,  4'd2, 1'b1, 18'd3,  8'd3}};

  initial forever @(posedge clk) cyc++;

  // converter model: done two cycles after the request, code = {pos, count}
  initial forever begin
    @(negedge clk);
    conv_done = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin conv_done = 1; conv_data = {conv_pos, 8'(conv_k)}; conv_k++; end
    end
    if (conv_start) begin
      pend = 2;
      if (armed) begin
        st_cyc = cyc; cap_pos = conv_pos; cap_neg = conv_neg; cap_diff = conv_diff; armed = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = 6'(a);
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic wait_eos();
    logic [31:0] s;
    for (int t = 0; t < 3000; t++) begin
      rd(3, s);
      if (s[1]) return;
    end
    chk("R8 eos timeout", 0, 1);
  endtask

  function automatic logic [31:0] cfg_word(input logic [1:0] mode, input logic [2:0] avg,
      input logic [3:0] neg, input logic [3:0] pos, input logic diff, input logic fifo);
    return {5'd0, fifo, diff, 2'd0, pos, neg, 10'd0, avg, mode};
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd(1, d); chk("R1 status", d, 32'h10);
    rd(5, d); chk("R1 fifo0 count", d, 0);
    rd(8, d); chk("R1 fifo1 count", d, 0);
    rd(2, d); chk("R1 arm", d, 0);
    chk("R1 irq_o", irq, 0);

    for (int i = 0; i < 5; i++) begin
      automatic int step = i * 3;
      automatic int n = (VEC[i].avg > 4) ? 16 : (1 << VEC[i].avg);
      automatic int exp = VEC[i].pos * 256 + (n - 1) / 2;
      automatic int fo = VEC[i].fifo ? 8 : 5;
      automatic int fn = VEC[i].fifo ? 5 : 8;
      wr(0, 0);
      wr(32 + 2*step, cfg_word(2'd0, VEC[i].avg, VEC[i].neg, VEC[i].pos, VEC[i].diff, VEC[i].fifo));
      wr(33 + 2*step, {VEC[i].smp, 6'd0, VEC[i].opn});
      wr(2, 32'(1) << (step + 1));
      wr(3, 32'h1ff);
      conv_k = 0; armed = 1;
      wr(0, 1);
      wait_eos();
      chk("R3 request delay", st_cyc - wr_cyc, VEC[i].opn + VEC[i].smp + 3);
      chk("R14 pos", cap_pos, VEC[i].pos);
      chk("R14 neg", cap_neg, VEC[i].neg);
      chk("R14 diff", cap_diff, VEC[i].diff);
      chk("R4 conversions", conv_k, n);
      rd(fo, d); chk("R5 selected count", d, 1);
      rd(fn, d); chk("R5 other count", d, 0);
      rd(fo + 2, d); chk("R4 averaged word", d, exp);
      rd(2, d); chk("R6 single-shot disarm", d, 0);
      rd(1, d); chk("R8 idle status", d, 32'h10);
    end

    // R2 ascending order; bit 0 arms nothing
    wr(0, 0); wr(3, 32'h1ff);
    wr(32 + 2, cfg_word(2'd0, 3'd0, 4'd8, 4'd2, 1'b0, 1'b0)); wr(33 + 2, 0);
    wr(32 + 10, cfg_word(2'd0, 3'd0, 4'd8, 4'd7, 1'b0, 1'b0)); wr(33 + 10, 0);
    wr(2, 32'h45);
    rd(2, d); chk("R2 bit0 reads 0", d, 32'h44);
    conv_k = 0;
    wr(0, 1);
    wait_eos();
    rd(5, d); chk("R2 two results", d, 2);
    rd(7, d); chk("R2 step1 first", d, 32'h200);
    rd(7, d); chk("R2 step5 second", d, 32'h701);

    // R13 power-down holds the sequencer
    wr(0, 0); wr(3, 32'h1ff);
    wr(32 + 4, cfg_word(2'd0, 3'd0, 4'd8, 4'd4, 1'b0, 1'b0)); wr(33 + 4, 0);
    wr(2, 32'h8);
    wr(0, 32'h11);
    repeat (40) @(negedge clk);
    rd(5, d); chk("R13 no result under power-down", d, 0);
    rd(1, d); chk("R13 idle under power-down", d, 32'h10);
    rd(2, d); chk("R13 still armed", d, 32'h8);
    wr(0, 1);
    wait_eos();
    rd(5, d); chk("R13 runs after power-up", d, 1);
    rd(7, d);

    // R7 continuous, R9 overflow, R11 threshold
    wr(0, 0); wr(3, 32'h1ff); wr(9, 4);
    wr(32 + 8, cfg_word(2'd1, 3'd0, 4'd8, 4'd5, 1'b0, 1'b1)); wr(33 + 8, 0);
    wr(2, 32'h20);
    conv_k = 0;
    wr(0, 1);
    repeat (150) @(negedge clk);
    wr(0, 0);
    repeat (30) @(negedge clk);
    rd(1, d); chk("R8 stops when disabled", d, 32'h10);
    rd(2, d); chk("R7 continuous stays armed", d, 32'h20);
    rd(8, d); chk("R9 count saturates", d, 8);
    rd(3, d); chk("R11 fifo1 threshold", d[5], 1);
    chk("R9 fifo1 overflow", d[6], 1);
    chk("R9 fifo0 untouched", d[3], 0);
    for (int w = 0; w < 8; w++) begin
      rd(10, d);
      if (w == 0) chk("R9 first word kept", d, 32'h500);
      if (w == 7) chk("R9 eighth word kept", d, 32'h507);
    end
    rd(3, d); chk("R10 no underflow yet", d[7], 0);
    rd(10, d); chk("R10 empty read zero", d, 0);
    rd(3, d); chk("R10 fifo1 underflow", d[7], 1);

    // R12 enable mask and write-one-to-clear
    wr(4, 0);
    chk("R12 masked irq", irq, 0);
    wr(4, 32'h80);
    chk("R12 enabled irq", irq, 1);
    wr(3, 32'h80);
    chk("R12 cleared irq", irq, 0);
    rd(3, d); chk("R12 only written bit cleared", d[7:6], 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule